// File: doc/BRIEF.md
# Framed Command/Data Mailbox Port

This block is the device end of a byte-wide host mailbox with two addresses. Offset 0 is the data port. Offset 1 returns a status byte on a read and takes a command code on a write. A host opens a command frame with the normal-mode command. It then writes payload bytes one at a time, pacing itself on the input-buffer-full flag, and closes the frame with the end-of-command code. Each payload byte and the closing mark are passed to an internal agent over a valid/ready stream.

The agent answers over a second valid/ready stream, one byte per beat, and flags the final byte of the frame. The port wraps the answer in an in-band envelope. First comes a start marker (0x01) shown with the frame flag set. Then each payload byte is shown with output-buffer-full and the frame flag clear. Last comes an end marker (0x03), again with the frame flag set.

A cancel command returns both directions to idle from any state. It also pulses an abort line so the agent drops any partial work.

Back-pressure rules: a stream beat transfers on a clock edge where valid and ready are both high. `be_cmd_valid` stays high with stable data until it is accepted, unless a cancel withdraws it. `be_rsp_ready` is high only while the port's single response holding register is empty, during the payload phase of a frame. The agent must keep `be_rsp_valid` and its data stable until accepted, and may drop them only on `be_abort`. Each response frame carries at least one payload byte.

Top module: `mbox_port`

## Requirements
- R1: After reset the status byte reads 0x10 (ready-for-command alone), `be_cmd_valid` is low and `be_rsp_ready` is low.
- R2: The status byte (offset 1) has bit 0 output-buffer-full, bit 1 input-buffer-full, bit 2 frame flag, bit 3 error, bit 4 ready-for-command and bit 5 ready-for-data; bits 7:6 read 0. Reads at offset 0 return the byte being presented.
- R3: Writing command 0x01 while ready-for-command is set arms the port. Ready-for-data (bit 5) then sets, and ready-for-command and the error flag clear.
- R4: A data write to an armed port with input-buffer-full clear sets input-buffer-full and presents the byte on `be_cmd_data` with `be_cmd_end` low. The byte is held stable until accepted, and input-buffer-full is clear in the cycle after the accepting edge.
- R5: A data write while input-buffer-full is set is dropped, and the byte already waiting is kept.
- R6: Command 0x03 on an armed port with input-buffer-full clear sends one beat with `be_cmd_end` high and disarms the port. Once that beat is accepted, ready-for-command reads 1 again.
- R7: A data write while the port is not armed is not forwarded and sets the error flag (bit 3). The error flag is cleared by command 0x01 or by a cancel.
- R8: When the agent offers a response, the port presents the frame flag with output-buffer-full and data 0x01. It takes no agent byte until the host has read that marker.
- R9: Payload bytes are presented in agent order with output-buffer-full set and the frame flag clear. A host read at offset 0 clears output-buffer-full, and the next byte is taken only after that read.
- R10: After the host reads the byte that the agent marked last, the port presents the frame flag with output-buffer-full and data 0x03. Reading it returns the output side to idle.
- R11: Command 0x22 from any state makes the status read exactly 0x10 within two cycles. It withdraws any pending command beat and pulses `be_abort` high for one cycle.
- R12: Command codes other than 0x01, 0x03 and 0x22 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 1 | 0 data port, 1 status/command |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Status or presented byte, selected by host_addr |
| be_cmd_valid | output | 1 | Command beat to agent is valid |
| be_cmd_ready | input | 1 | Agent accepts the command beat |
| be_cmd_data | output | 8 | Command payload byte |
| be_cmd_end | output | 1 | Beat marks end of command frame (data unused) |
| be_rsp_valid | input | 1 | Agent response byte valid |
| be_rsp_ready | output | 1 | Port accepts a response byte |
| be_rsp_data | input | 8 | Response payload byte |
| be_rsp_last | input | 1 | Final byte of the response frame |
| be_abort | output | 1 | One-cycle pulse after a cancel |

## Verification
The framing is tried with a single-byte frame read at full speed and a four-byte frame read slowly. The slow read holds the agent off on back-pressure, and the pair separates marker sequencing from payload ordering. A deliberately stalled agent holds input-buffer-full, so a second write shows whether the held byte is kept or overwritten. Out-of-sequence inputs, namely data before arming and an unknown command code, show that the error flag is set only where intended. Cancels issued mid-response and while a command byte waits show whether both directions resynchronise and whether a fresh frame then passes cleanly.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CMD_NORMAL = 8'h01;
  localparam logic [BYTE_W-1:0] CMD_EOC    = 8'h03;
  localparam logic [BYTE_W-1:0] CMD_CANCEL = 8'h22;
  localparam logic [BYTE_W-1:0] MARK_HEAD  = 8'h01;
  localparam logic [BYTE_W-1:0] MARK_TAIL  = 8'h03;

  typedef enum logic [1:0] {EG_IDLE, EG_HEAD, EG_BODY, EG_TAIL} eg_state_t;

  // status byte layout, bit 5 down to bit 0
  typedef struct packed {
    logic ibr;   // ready for data
    logic rdy;   // ready for command
    logic err;   // data written while not armed
    logic f0;    // frame marker on the data port
    logic ibf;   // input byte waiting for the agent
    logic obf;   // output byte waiting for the host
  } stat_t;
endpackage

// File: rtl/mbox_ingress.sv
module mbox_ingress
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] data_in,
  input  logic              cmd_normal,
  input  logic              cmd_eoc,
  output logic              armed,
  output logic              ibf,
  output logic              err,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [BYTE_W-1:0] cmd_data,
  output logic              cmd_end
);
  logic              armed_q, ibf_q, err_q, end_q;
  logic [BYTE_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      armed_q <= 1'b0;
      ibf_q   <= 1'b0;
      err_q   <= 1'b0;
      end_q   <= 1'b0;
      hold_q  <= '0;
    end else begin
      if (ibf_q && cmd_ready) ibf_q <= 1'b0;
      if (data_wr) begin
        if (!armed_q) begin
          err_q <= 1'b1;
        end else if (!ibf_q) begin
          hold_q <= data_in;
          end_q  <= 1'b0;
          ibf_q  <= 1'b1;
        end
      end
      if (cmd_normal && !armed_q && !ibf_q) begin
        armed_q <= 1'b1;
        err_q   <= 1'b0;
      end
      if (cmd_eoc && armed_q && !ibf_q) begin
        end_q   <= 1'b1;
        ibf_q   <= 1'b1;
        armed_q <= 1'b0;
      end
    end
  end

  assign armed     = armed_q;
  assign ibf       = ibf_q;
  assign err       = err_q;
  assign cmd_valid = ibf_q;
  assign cmd_data  = hold_q;
  assign cmd_end   = end_q;
endmodule

// File: rtl/mbox_egress.sv
module mbox_egress
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              host_take,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [BYTE_W-1:0] rsp_data,
  input  logic              rsp_last,
  output logic              obf,
  output logic              f0,
  output logic [BYTE_W-1:0] out_byte
);
  eg_state_t         st_q;
  logic              full_q, last_q;
  logic [BYTE_W-1:0] byte_q;

  assign rsp_ready = (st_q == EG_BODY) && !full_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      st_q   <= EG_IDLE;
      full_q <= 1'b0;
      last_q <= 1'b0;
      byte_q <= '0;
    end else begin
      unique case (st_q)
        EG_IDLE: if (rsp_valid) st_q <= EG_HEAD;
        EG_HEAD: if (host_take) st_q <= EG_BODY;
        EG_BODY: begin
          if (rsp_valid && rsp_ready) begin
            full_q <= 1'b1;
            byte_q <= rsp_data;
            last_q <= rsp_last;
          end else if (host_take && full_q) begin
            full_q <= 1'b0;
            if (last_q) st_q <= EG_TAIL;
          end
        end
        EG_TAIL: if (host_take) st_q <= EG_IDLE;
        default: st_q <= EG_IDLE;
      endcase
    end
  end

  always_comb begin
    f0       = (st_q == EG_HEAD) || (st_q == EG_TAIL);
    obf      = f0 || ((st_q == EG_BODY) && full_q);
    out_byte = byte_q;
    if (st_q == EG_HEAD) out_byte = MARK_HEAD;
    if (st_q == EG_TAIL) out_byte = MARK_TAIL;
  end
endmodule

// File: rtl/mbox_port.sv
module mbox_port
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              be_cmd_valid,
  input  logic              be_cmd_ready,
  output logic [BYTE_W-1:0] be_cmd_data,
  output logic              be_cmd_end,
  input  logic              be_rsp_valid,
  output logic              be_rsp_ready,
  input  logic [BYTE_W-1:0] be_rsp_data,
  input  logic              be_rsp_last,
  output logic              be_abort
);
  localparam int STAT_W = $bits(stat_t);

  logic wr_cmd, wr_data, rd_data;
  logic do_cancel, do_normal, do_eoc;
  logic armed, ibf, err, obf, f0;
  logic abort_q;
  logic [BYTE_W-1:0] out_byte;
  stat_t             stat;
  logic [BYTE_W-1:0] status_w;

  assign wr_cmd    = host_wr && host_addr;
  assign wr_data   = host_wr && !host_addr;
  assign rd_data   = host_rd && !host_addr;
  assign do_cancel = wr_cmd && (host_wdata == CMD_CANCEL);
  assign do_normal = wr_cmd && (host_wdata == CMD_NORMAL);
  assign do_eoc    = wr_cmd && (host_wdata == CMD_EOC);

  mbox_ingress i_ingress (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (do_cancel),
    .data_wr    (wr_data),
    .data_in    (host_wdata),
    .cmd_normal (do_normal),
    .cmd_eoc    (do_eoc),
    .armed      (armed),
    .ibf        (ibf),
    .err        (err),
    .cmd_valid  (be_cmd_valid),
    .cmd_ready  (be_cmd_ready),
    .cmd_data   (be_cmd_data),
    .cmd_end    (be_cmd_end)
  );

  mbox_egress i_egress (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (do_cancel),
    .host_take (rd_data),
    .rsp_valid (be_rsp_valid),
    .rsp_ready (be_rsp_ready),
    .rsp_data  (be_rsp_data),
    .rsp_last  (be_rsp_last),
    .obf       (obf),
    .f0        (f0),
    .out_byte  (out_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) abort_q <= 1'b0;
    else        abort_q <= do_cancel;
  end
  assign be_abort = abort_q;

  always_comb begin
    stat.ibr = armed;
    stat.rdy = !armed && !ibf;
    stat.err = err;
    stat.f0  = f0;
    stat.ibf = ibf;
    stat.obf = obf;
  end

  assign status_w   = {{(BYTE_W-STAT_W){1'b0}}, stat};
  assign host_rdata = host_addr ? status_w : out_byte;
endmodule

// File: rtl/mbox_port_chk.sv
module mbox_port_chk
  import mbox_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              host_addr,
  input logic              host_wr,
  input logic              host_rd,
  input logic [BYTE_W-1:0] host_wdata,
  input logic [BYTE_W-1:0] status,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [BYTE_W-1:0] cmd_data,
  input logic              cmd_end,
  input logic              abort
);
  logic cancel_w;
  assign cancel_w = host_wr && host_addr && (host_wdata == CMD_CANCEL);

  assert_cancel_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_w |=> (status == 8'h10));

  assert_abort_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_w |=> abort);

  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !cancel_w) |=> (cmd_valid && $stable(cmd_data) && $stable(cmd_end)));

  assert_ibf_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !status[1]);

  assert_idle_write_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_addr && !status[5]) |=> status[3]);

  assert_normal_arms_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr && (host_wdata == CMD_NORMAL) && status[4]) |=> (status[5] && !status[4] && !status[3]));

  assert_take_clears_obf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_addr && !host_wr && status[0] && !status[2]) |=> (!status[0] || status[2]));
endmodule

bind mbox_port mbox_port_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_addr  (host_addr),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_wdata (host_wdata),
  .status     (status_w),
  .cmd_valid  (be_cmd_valid),
  .cmd_ready  (be_cmd_ready),
  .cmd_data   (be_cmd_data),
  .cmd_end    (be_cmd_end),
  .abort      (be_abort)
);

// File: tb/test_mbox_port.sv
module test_mbox_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_addr = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       be_cmd_valid, be_cmd_ready, be_cmd_end;
  logic [7:0] be_cmd_data;
  logic       be_rsp_valid, be_rsp_ready, be_rsp_last;
  logic [7:0] be_rsp_data;
  logic       be_abort;

  int checks = 0, errors = 0, abort_cnt = 0, end_beats = 0;
  bit stall = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] agent_in[$];
  logic [8:0] rsp_q[$];

  always #10 clk = ~clk;

  mbox_port i_mbox_port (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .be_cmd_valid(be_cmd_valid), .be_cmd_ready(be_cmd_ready), .be_cmd_data(be_cmd_data),
    .be_cmd_end(be_cmd_end), .be_rsp_valid(be_rsp_valid), .be_rsp_ready(be_rsp_ready),
    .be_rsp_data(be_rsp_data), .be_rsp_last(be_rsp_last), .be_abort(be_abort)
  );

  always @(posedge clk) if (be_abort) abort_cnt++;

  // loopback agent: echoes each command frame back as the response
  initial begin
    be_cmd_ready = 1'b0; be_rsp_valid = 1'b0; be_rsp_data = 8'h00; be_rsp_last = 1'b0;
    forever begin
      @(negedge clk);
      if (be_abort) begin agent_in.delete(); rsp_q.delete(); end
      be_cmd_ready = !stall;
      be_rsp_valid = (rsp_q.size() != 0);
      if (be_rsp_valid) {be_rsp_last, be_rsp_data} = rsp_q[0];
      #1;
      if (be_cmd_valid && be_cmd_ready) begin
        if (be_cmd_end) begin
          end_beats++;
          for (int i = 0; i < agent_in.size(); i++)
            rsp_q.push_back({(i == agent_in.size() - 1), agent_in[i]});
          agent_in.delete();
        end else agent_in.push_back(be_cmd_data);
      end
      if (be_rsp_valid && be_rsp_ready) void'(rsp_q.pop_front());
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic hr(input logic a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = 1'b1;
    #2 d = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic wait_stat(input logic [7:0] mask, input logic [7:0] val, output logic [7:0] s);
    for (int n = 0; n < 2000; n++) begin
      hr(1'b1, s);
      if ((s & mask) == val) return;
    end
    chk("status poll timeout", int'(s & mask), int'(val));
  endtask

  // driver: sends one command frame and records the expected echo
  task automatic send_frame(input logic [7:0] b[$]);
    logic [7:0] s;
    hw(1'b1, 8'h01);
    wait_stat(8'h20, 8'h20, s);
    foreach (b[i]) begin
      wait_stat(8'h02, 8'h00, s);
      hw(1'b0, b[i]);
      exp_q.push_back(b[i]);
    end
    wait_stat(8'h02, 8'h00, s);
    hw(1'b1, 8'h03);
  endtask

  // monitor: reads one response frame and pops expected bytes
  task automatic recv_frame(input int gap);
    logic [7:0] s, d;
    wait_stat(8'h04, 8'h04, s);
    chk("R8 head status obf", int'(s[0]), 1);
    hr(1'b0, d);
    chk("R8 R2 head marker", d, 8'h01);
    forever begin
      repeat (gap) @(negedge clk);
      wait_stat(8'h01, 8'h01, s);
      if (s[2]) break;
      hr(1'b0, d);
      if (exp_q.size() == 0) chk("R9 unexpected byte", d, -1);
      else chk("R9 payload byte", d, exp_q.pop_front());
    end
    hr(1'b0, d);
    chk("R10 tail marker", d, 8'h03);
    chk("R9 all bytes seen", exp_q.size(), 0);
    hr(1'b1, s);
    chk("R10 idle after tail", s, 8'h10);
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    int ab;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    hr(1'b1, s);
    chk("R1 R2 reset status", s, 8'h10);
    chk("R1 cmd_valid", be_cmd_valid, 0);
    chk("R1 rsp_ready", be_rsp_ready, 0);

    hw(1'b1, 8'h55);
    hr(1'b1, s);
    chk("R12 unknown code", s, 8'h10);

    hw(1'b0, 8'h77);
    hr(1'b1, s);
    chk("R7 error flag", s, 8'h18);
    chk("R7 not forwarded", be_cmd_valid, 0);

    hw(1'b1, 8'h01);
    hr(1'b1, s);
    chk("R3 armed status", s, 8'h20);

    stall = 1'b1;
    hw(1'b0, 8'hA5);
    hr(1'b1, s);
    chk("R4 ibf set", s, 8'h22);
    chk("R4 byte presented", be_cmd_data, 8'hA5);
    hw(1'b0, 8'h5A);
    hr(1'b1, s);
    chk("R5 still full", s, 8'h22);
    chk("R5 held byte kept", be_cmd_data, 8'hA5);
    stall = 1'b0;
    repeat (3) @(negedge clk);
    hr(1'b1, s);
    chk("R4 ibf cleared", s, 8'h20);
    chk("R5 one byte delivered", agent_in.size(), 1);
    exp_q.push_back(8'hA5);

    hw(1'b1, 8'h03);
    wait_stat(8'h12, 8'h10, s);
    chk("R6 end beat sent", end_beats, 1);
    chk("R6 disarmed", int'(s[5]), 0);
    recv_frame(0);

    send_frame('{8'h11, 8'h22, 8'h33, 8'h44});
    recv_frame(6);
    send_frame('{8'hFF});
    recv_frame(0);

    // cancel in the middle of a response
    send_frame('{8'hC1, 8'hC2, 8'hC3});
    wait_stat(8'h04, 8'h04, s);
    hr(1'b0, d);
    chk("R8 head marker", d, 8'h01);
    wait_stat(8'h01, 8'h01, s);
    hr(1'b0, d);
    chk("R9 first byte", d, 8'hC1);
    ab = abort_cnt;
    hw(1'b1, 8'h22);
    hr(1'b1, s);
    chk("R11 status after cancel", s, 8'h10);
    chk("R11 abort pulse", abort_cnt - ab, 1);
    exp_q.delete();
    repeat (10) @(negedge clk);
    hr(1'b1, s);
    chk("R11 stays idle", s, 8'h10);

    // cancel with a command byte waiting
    stall = 1'b1;
    hw(1'b1, 8'h01);
    hw(1'b0, 8'h99);
    hw(1'b1, 8'h22);
    hr(1'b1, s);
    chk("R11 status with byte pending", s, 8'h10);
    chk("R11 beat withdrawn", be_cmd_valid, 0);
    stall = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 agent flushed", agent_in.size(), 0);

    send_frame('{8'h5E, 8'h6F});
    recv_frame(1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule